// File: doc/BRIEF.md
# Masked Interrupt Status Unit with Acknowledge

This unit keeps the eight-bit interrupt status and the eight-bit interrupt enable mask of a network controller and drives one level-sensitive interrupt line. Event pulses from the receive path and from five general sources set status bits. Two bits are not stored events. They are conditions that are re-derived on every clock from the state of the transmit side: the transmit queue being idle, and completed transmissions still waiting to be collected.

The host clears bits by writing an acknowledge value. Only a fixed subset of the bits can be cleared this way. When the acknowledge has the transmit bit set, the unit also asks the external completion queue to drop its head entry. That pop is already taken into account when the transmit bit is recomputed in the same update. Because the two derived bits are forced back on while their condition holds, acknowledging them has no lasting effect until the condition goes away.

The queues and the bus decode live outside this block. All pins are plain control and status signals, with no handshake, because every write completes in one cycle.

Top module: `irq_unit`

## Requirements
- R1: While reset is asserted and at the first edge after it, `status`, `mask` and `irq` are all zero, and `done_pop` is low whenever `done_count` is zero.
- R2: Status bits are set one edge after their event and stay set until an acknowledge clears them or reset:
  - `rx_event` sets bit 0.
  - `ext_event[k]` sets bit 3+k.
- R3: At every edge, bit 2 takes the value 1 when `tx_idle` is high, whatever acknowledge is written in that cycle.
- R4: At every edge, bit 1 takes the value 1 when `done_count` minus the pop issued in that cycle is non-zero, whatever acknowledge is written in that cycle.
- R5: An acknowledge write (`ack_we` high) clears, at the next edge, only the bits set both in `ack_val` and in 0xD6, which are bits 1, 2, 4, 6 and 7. Bits 0, 3 and 5 are never cleared by an acknowledge.
- R6: `done_pop` is high, combinationally in the same cycle, exactly when `ack_we` is high, `ack_val[1]` is 1 and `done_count` is non-zero.
- R7: When an event and an acknowledge that clears its bit arrive in the same cycle, the bit is 1 after the edge.
- R8: `mask_we` loads `mask_val` into `mask` at the next edge. Otherwise `mask` holds its value.
- R9: `irq` is a registered output. After every edge it equals the OR of (`status` AND `mask`) as updated at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_event | input | 1 | Frame-received pulse, sets bit 0 |
| ext_event | input | 5 | General event pulses, set bits 3..7 |
| tx_idle | input | 1 | Transmit queue holds no entries |
| done_count | input | CNT_W (3) | Entries in the transmit-completion queue |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_val | input | 8 | Acknowledge value |
| mask_we | input | 1 | Mask write strobe |
| mask_val | input | 8 | Mask value |
| done_pop | output | 1 | Pop request to the completion queue |
| status | output | 8 | Interrupt status byte |
| mask | output | 8 | Interrupt enable mask |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the following corner cases:
- **Acknowledging the transmit bit while exactly one completion is pending.** A design that recomputed the bit from the un-popped count would leave it stuck on for an extra cycle.
- **Acknowledging the transmit bit with an empty completion queue.** A design that popped anyway would corrupt the external queue.
- **Writing 0xFF to the acknowledge register.** This exposes designs that clear the receive bit or bits 3 and 5, or that let an acknowledge beat an event or the idle condition arriving in the same cycle.
- **Mask changes in the same cycle as status changes.** A wrong design would show the interrupt line lagging by one cycle.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned RX_BIT   = 0;
  localparam int unsigned TX_BIT   = 1;
  localparam int unsigned IDLE_BIT = 2;
  localparam int unsigned EXT_LO   = 3;
  localparam int unsigned EXT_W    = STAT_W - EXT_LO;
  localparam logic [STAT_W-1:0] ACK_CLEARABLE = 8'hD6;
endpackage

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] force_vec,
  output logic [W-1:0] status_d,
  output logic [W-1:0] status_q
);
  // Per-bit priority: forced condition, then event, then hold unless cleared.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign status_d[i] = force_vec[i] | set_vec[i] | (status_q[i] & ~clr_vec[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= status_d[i];
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_d,
  output logic [W-1:0] mask_q
);
  assign mask_d = we ? wdata : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_done_pop.sv
module irq_done_pop #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             ack_we,
  input  logic             ack_tx,
  input  logic [CNT_W-1:0] count,
  output logic             pop,
  output logic             left_nonzero
);
  logic             have;
  logic [CNT_W-1:0] left;

  assign have         = |count;
  assign pop          = ack_we & ack_tx & have;
  assign left         = count - CNT_W'(pop);
  assign left_nonzero = |left;
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_unit_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_event,
  input  logic [EXT_W-1:0]  ext_event,
  input  logic              tx_idle,
  input  logic [CNT_W-1:0]  done_count,
  input  logic              ack_we,
  input  logic [STAT_W-1:0] ack_val,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_val,
  output logic              done_pop,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  logic              left_nz;
  logic [STAT_W-1:0] set_vec, clr_vec, force_vec;
  logic [STAT_W-1:0] status_d, mask_d;

  irq_done_pop #(.CNT_W(CNT_W)) u_pop (
    .ack_we       (ack_we),
    .ack_tx       (ack_val[TX_BIT]),
    .count        (done_count),
    .pop          (done_pop),
    .left_nonzero (left_nz)
  );

  always_comb begin
    set_vec                      = '0;
    set_vec[RX_BIT]              = rx_event;
    set_vec[STAT_W-1:EXT_LO]     = ext_event;
    force_vec                    = '0;
    force_vec[TX_BIT]            = left_nz;
    force_vec[IDLE_BIT]          = tx_idle;
    clr_vec                      = ack_we ? (ack_val & ACK_CLEARABLE) : '0;
  end

  irq_status_bits #(.W(STAT_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .force_vec (force_vec),
    .status_d  (status_d),
    .status_q  (status)
  );

  irq_mask_reg #(.W(STAT_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (mask_we),
    .wdata  (mask_val),
    .mask_d (mask_d),
    .mask_q (mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status_d & mask_d);
  end
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk
  import irq_unit_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_event,
  input logic [EXT_W-1:0]  ext_event,
  input logic              tx_idle,
  input logic [CNT_W-1:0]  done_count,
  input logic              ack_we,
  input logic [STAT_W-1:0] ack_val,
  input logic              mask_we,
  input logic [STAT_W-1:0] mask_val,
  input logic              done_pop,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] mask,
  input logic              irq
);
  // R3
  idle_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |=> status[IDLE_BIT]);
  // R4
  done_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_count > CNT_W'(1)) |=> status[TX_BIT]);
  // R2
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |=> status[RX_BIT]);
  // R5
  rx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[RX_BIT] |=> status[RX_BIT]);
  // R6
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_count == '0) |-> !done_pop);
  // R6
  pop_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pop |-> (ack_we && ack_val[TX_BIT]));
  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask == $past(mask_val)));
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask));
  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |(status & mask)));
endmodule

bind irq_unit irq_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_event(rx_event), .ext_event(ext_event),
  .tx_idle(tx_idle), .done_count(done_count), .ack_we(ack_we),
  .ack_val(ack_val), .mask_we(mask_we), .mask_val(mask_val),
  .done_pop(done_pop), .status(status), .mask(mask), .irq(irq)
);

// File: tb/irq_unit_test.sv
`timescale 1ns/1ps
module irq_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_event = 1'b0;
  logic [4:0] ext_event = '0;
  logic       tx_idle = 1'b0;
  logic [2:0] done_count = '0;
  logic       ack_we = 1'b0;
  logic [7:0] ack_val = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_val = '0;
  logic       done_pop;
  logic [7:0] status, mask;
  logic       irq;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;
  int m_st = 0, m_mk = 0, m_irq = 0, m_cnt = 0;

  always #4 clk = ~clk;

  irq_unit uut (
    .clk(clk), .rst_n(rst_n), .rx_event(rx_event), .ext_event(ext_event),
    .tx_idle(tx_idle), .done_count(done_count), .ack_we(ack_we),
    .ack_val(ack_val), .mask_we(mask_we), .mask_val(mask_val),
    .done_pop(done_pop), .status(status), .mask(mask), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive, check pop, model the update, check after the edge.
  task automatic step(input string tag, input bit rx, input int ext,
                      input bit idle, input bit awe, input int av,
                      input bit mwe, input int mv);
    int pop, clr, nst;
    @(negedge clk);
    rx_event = rx; ext_event = ext[4:0]; tx_idle = idle;
    ack_we = awe; ack_val = av[7:0]; mask_we = mwe; mask_val = mv[7:0];
    done_count = m_cnt[2:0];
    pop = (awe && av[1] && m_cnt != 0) ? 1 : 0;
    #1 check({tag, " R6 pop"}, int'(done_pop), pop);
    clr = awe ? (av & 'hD6) : 0;
    nst = (m_st & ~clr) | (rx ? 1 : 0) | ((ext & 'h1F) << 3);
    if (idle) nst = nst | 4;
    if (m_cnt - pop != 0) nst = nst | 2;
    m_st = nst & 'hFF;
    if (mwe) m_mk = mv & 'hFF;
    m_irq = ((m_st & m_mk) != 0) ? 1 : 0;
    m_cnt = m_cnt - pop;
    @(posedge clk);
    #2;
    check({tag, " status"}, int'(status), m_st);
    check({tag, " R8 mask"}, int'(mask), m_mk);
    check({tag, " R9 irq"}, int'(irq), m_irq);
  endtask

  task automatic idle_step(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("R1 status", int'(status), 0);
    check("R1 mask", int'(mask), 0);
    check("R1 irq", int'(irq), 0);
    @(negedge clk) rst_n = 1'b1;
    idle_step("R1 first");

    // R8: mask load and hold
    step("R8 load", 0, 0, 0, 0, 0, 1, 'hFF);
    idle_step("R8 hold");

    // R2: receive and general events, sticky
    step("R2 rx", 1, 0, 0, 0, 0, 0, 0);
    step("R2 ext", 0, 'h15, 0, 0, 0, 0, 0);
    idle_step("R2 sticky");

    // R5: acknowledge all clears only 0xD6 bits
    step("R5 ack all", 0, 0, 0, 1, 'hFF, 0, 0);
    step("R5 ext hi", 0, 'h1F, 0, 0, 0, 0, 0);
    step("R5 ack all again", 0, 0, 0, 1, 'hFF, 0, 0);

    // R3: idle forces bit 2 even against acknowledge
    step("R3 idle+ack", 0, 0, 1, 1, 'h04, 0, 0);
    step("R3 gone+ack", 0, 0, 0, 1, 'h04, 0, 0);

    // R4 / R6: completions pending, pop one at a time
    m_cnt = 2;
    idle_step("R4 pending");
    step("R4 ack pops 2->1", 0, 0, 0, 1, 'h02, 0, 0);
    step("R4 ack pops last", 0, 0, 0, 1, 'h02, 0, 0);
    step("R6 ack empty no pop", 0, 0, 0, 1, 'h02, 0, 0);
    step("R6 ack other bit no pop", 0, 0, 0, 1, 'h04, 0, 0);
    m_cnt = 1;
    step("R6 ack without strobe", 0, 0, 0, 0, 'h02, 0, 0);
    step("R4 single pop", 0, 0, 0, 1, 'h02, 0, 0);

    // R7: event beats acknowledge in the same cycle
    step("R7 ext vs ack", 0, 'h02, 0, 1, 'h10, 0, 0);

    // R9: mask gating, same-cycle mask change
    step("R9 mask off", 0, 0, 0, 0, 0, 1, 'h00);
    step("R9 mask on rx", 0, 0, 0, 0, 0, 1, 'h01);
    step("R9 mask to tx only", 0, 0, 0, 0, 0, 1, 'h02);

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      if (r[20] && m_cnt < 4) m_cnt = m_cnt + 1;
      step("mix R2 R3 R4 R5 R7", r[0], (r[1] && r[2]) ? int'(r[7:3]) : 0,
           r[8], r[9], int'(r[17:10]), r[18] && r[19], int'(r[27:20]));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule